// File: doc/BRIEF.md
# Set-Associative Software-Filled Translation Buffer Lookup

This block answers address-translation lookups against a small translation buffer. Software loads the buffer, and no hardware page-table walk exists. The buffer is set-associative. Its storage is split into a data half and an instruction half. A lookup carries five inputs:

- an effective address
- an access kind (load, store or fetch)
- a precomputed page-table match word
- a protection key
- a no-execute flag

The block reads one entry per way from the half that the access kind selects. It compares each entry's stored page number and match field, drops later matches that disagree with the first accepted one, and derives the access permissions. It then reports a hit, a protection fault or a miss.

The reply is registered and appears one cycle after the request. In the same clock edge, a match writes the referenced bit back into the chosen entry. A granted store also writes the changed bit if it was clear. Until that bit is set, every other access gets its returned permissions with write removed, so that the first write to a page traps. When no way matches, the match word is captured in a per-side miss-compare register, for use by the refill handler. Software writes entries through a one-cycle write port that addresses an entry by its flat index.

Top module: `xlatBufLookup`

## Requirements
- R1: The set index is address bits [PAGE_BITS +: log2(ENTRIES_PER_WAY)]. The flat entry index is set + way*ENTRIES_PER_WAY for loads and stores, plus NUM_WAYS*ENTRIES_PER_WAY for fetches. Fetches therefore never see data-half entries, and addresses past the last set wrap to set 0.
- R2: A way matches only when all four of these hold:
  - the stored page number equals address bits [31:PAGE_BITS]
  - word-0 bit 31 (valid) is 1
  - word-0 bit 6 (hash select) is 0
  - word-0 bits 30:7 and 5:0 equal the same bits of the match word
- R3: Once a way is accepted, a later matching way is ignored if its word-1 page-frame bits 31:12, attribute bits 6:3 or permission bits 1:0 differ from the accepted word.
- R4: Permissions come from the key and word-1 bits 1:0 (pp). Returned protection is {exec, write, read}.
  - Key 0 always grants read, and grants write unless pp=3.
  - Key 1 grants read unless pp=0, and grants write only for pp=2.
  - Exec equals read when the no-execute flag is 0.
  - Access kind 00 is load (needs read), 01 is store (needs write), 10 is fetch (needs exec). Kind 11 behaves as a load.
- R5: Result code 00 means hit: the first accepted way permits the access, and the search stops there. Code 01 means fault: ways were accepted but none permits the access. Code 10 means miss: no way was accepted. A miss returns zero protection and a zero real address.
- R6: On a hit or a fault, word-1 bit 8 (referenced) is set in the last accepted entry. The reply's entry word shows the written-back value.
- R7: If word-1 bit 7 (changed) is clear, a granted store sets it and keeps write. Any other access returns its protection with write cleared. Once the bit is set, later accesses keep write.
- R8: A miss by a fetch copies the match word into the instruction miss-compare register. A miss by any other access copies it into the data miss-compare register. The other register is unchanged.
- R9: The reply (valid, code, protection, real address {word-1 bits 31:PAGE_BITS, address offset}, entry word) is registered one cycle after a request. Reply-valid is 0 in cycles with no request.
- R10: After reset, reply-valid is 0, both miss-compare registers are 0 and every entry is invalid.
- R11: A write stores the page number and both words at its flat index. When it targets the entry that a same-cycle lookup updates, the write wins, and the lookup replies from the contents before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request strobe |
| reqAddr | input | 32 | Effective address |
| reqAcc | input | 2 | Access kind: 00 load, 01 store, 10 fetch |
| reqMatch | input | 32 | Page-table match word |
| reqKey | input | 1 | Protection key |
| reqNoExec | input | 1 | No-execute flag |
| wrEn | input | 1 | Entry write strobe |
| wrIdx | input | 7 | Flat entry index to write |
| wrEpn | input | 20 | Page number to store |
| wrWord0 | input | 32 | Entry word 0 (valid, hash select, match field) |
| wrWord1 | input | 32 | Entry word 1 (frame, referenced, changed, attributes, pp) |
| rspValid | output | 1 | Reply valid |
| rspCode | output | 2 | 00 hit, 01 fault, 10 miss |
| rspProt | output | 3 | Returned {exec, write, read} |
| rspRealAddr | output | 32 | Translated address |
| rspPte | output | 32 | Chosen entry word 1 after write-back |
| missCmpInstr | output | 32 | Instruction-side miss-compare register |
| missCmpData | output | 32 | Data-side miss-compare register |

## Verification
A request driven before a rising edge has its reply fields and miss-compare updates due right after that edge. The bench samples them at the next falling edge. Referenced and changed write-backs, and port writes, appear in the first lookup issued in a following cycle. The bench therefore updates its behavioural entry model in the same step as the reply it checks. In cycles with no request, the bench checks that reply-valid is low and that both miss-compare registers hold their values.

// File: rtl/xlatBufPkg.sv
package xlatBufPkg;

  localparam int WORD_W = 32;

  localparam logic [1:0] ACC_LOAD  = 2'b00;
  localparam logic [1:0] ACC_STORE = 2'b01;
  localparam logic [1:0] ACC_FETCH = 2'b10;

  localparam logic [1:0] RES_HIT   = 2'b00;
  localparam logic [1:0] RES_FAULT = 2'b01;
  localparam logic [1:0] RES_MISS  = 2'b10;

  localparam int VALID_BIT = 31;
  localparam int HSEL_BIT  = 6;
  localparam int REF_BIT   = 8;
  localparam int CHG_BIT   = 7;

  // bits of word 0 that take part in the match compare
  localparam logic [WORD_W-1:0] MATCH_MASK   = 32'h7FFF_FFBF;
  // frame, attribute and pp bits of word 1 that matching ways must share
  localparam logic [WORD_W-1:0] CONSIST_MASK = 32'hFFFF_F07B;

  // strobes from control to datapath
  typedef struct packed {
    logic       respond;
    logic [1:0] code;
    logic       setRef;
    logic       latchImiss;
    logic       latchDmiss;
  } xlatStrobe_t;

  // protection as {exec, write, read}
  function automatic logic [2:0] permOf(input logic key, input logic [1:0] pp,
                                        input logic noExec);
    logic rd;
    logic wr;
    if (!key) begin
      rd = 1'b1;
      wr = (pp != 2'b11);
    end else begin
      rd = (pp != 2'b00);
      wr = (pp == 2'b10);
    end
    return {rd & ~noExec, wr, rd};
  endfunction

  function automatic logic accessOk(input logic [2:0] prot, input logic [1:0] acc);
    case (acc)
      ACC_FETCH: return prot[2];
      ACC_STORE: return prot[1];
      default:   return prot[0];
    endcase
  endfunction

endpackage

// File: rtl/xlatBufCtrl.sv
module xlatBufCtrl
  import xlatBufPkg::*;
#(
  parameter int ENTRIES_PER_WAY = 32,
  parameter int NUM_WAYS        = 2,
  parameter int PAGE_BITS       = 12,
  localparam int SET_W = $clog2(ENTRIES_PER_WAY),
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int EPN_W = WORD_W - PAGE_BITS
) (
  input  logic              reqValid,
  input  logic [WORD_W-1:0] reqAddr,
  input  logic [1:0]        reqAcc,
  input  logic [WORD_W-1:0] reqMatch,
  input  logic              reqKey,
  input  logic              reqNoExec,
  input  logic [EPN_W-1:0]  rdEpn [NUM_WAYS],
  input  logic [WORD_W-1:0] rdW0  [NUM_WAYS],
  input  logic [WORD_W-1:0] rdW1  [NUM_WAYS],
  output logic [SET_W-1:0]  lookupSet,
  output logic              isFetch,
  output xlatStrobe_t       strobe,
  output logic [WAY_W-1:0]  bestWay,
  output logic [2:0]        protOut,
  output logic [WORD_W-1:0] pteOut,
  output logic [WORD_W-1:0] realAddrOut
);

  logic              found;
  logic              granted;
  logic              stopScan;
  logic              wayMatch;
  logic              setChg;
  logic [2:0]        prot;
  logic [WORD_W-1:0] chosenW1;

  always_comb begin
    isFetch   = (reqAcc == ACC_FETCH);
    lookupSet = reqAddr[PAGE_BITS +: SET_W];
    found     = 1'b0;
    granted   = 1'b0;
    stopScan  = 1'b0;
    wayMatch  = 1'b0;
    bestWay   = '0;
    chosenW1  = '0;
    prot      = '0;
    // ordered scan: earlier ways take precedence, later ones must agree
    for (int w = 0; w < NUM_WAYS; w++) begin
      wayMatch = rdW0[w][VALID_BIT] && !rdW0[w][HSEL_BIT] &&
                 (((rdW0[w] ^ reqMatch) & MATCH_MASK) == '0) &&
                 (rdEpn[w] == reqAddr[WORD_W-1:PAGE_BITS]);
      if (!stopScan && wayMatch &&
          (!found || (((rdW1[w] ^ chosenW1) & CONSIST_MASK) == '0))) begin
        found    = 1'b1;
        bestWay  = WAY_W'(w);
        chosenW1 = rdW1[w];
        prot     = permOf(reqKey, rdW1[w][1:0], reqNoExec);
        if (accessOk(prot, reqAcc)) begin
          granted  = 1'b1;
          stopScan = 1'b1;
        end
      end
    end

    setChg = found && granted && (reqAcc == ACC_STORE) && !chosenW1[CHG_BIT];
    if (found && !chosenW1[CHG_BIT] && !setChg) begin
      prot[1] = 1'b0;
    end

    pteOut = chosenW1;
    if (found) begin
      pteOut[REF_BIT] = 1'b1;
    end
    if (setChg) begin
      pteOut[CHG_BIT] = 1'b1;
    end

    protOut     = found ? prot : 3'b000;
    realAddrOut = found ? {chosenW1[WORD_W-1:PAGE_BITS], reqAddr[PAGE_BITS-1:0]} : '0;

    strobe.respond    = reqValid;
    strobe.code       = granted ? RES_HIT : (found ? RES_FAULT : RES_MISS);
    strobe.setRef     = reqValid && found;
    strobe.latchImiss = reqValid && !found && isFetch;
    strobe.latchDmiss = reqValid && !found && !isFetch;
  end

endmodule

// File: rtl/xlatBufData.sv
module xlatBufData
  import xlatBufPkg::*;
#(
  parameter int ENTRIES_PER_WAY = 32,
  parameter int NUM_WAYS        = 2,
  parameter int PAGE_BITS       = 12,
  localparam int SET_W = $clog2(ENTRIES_PER_WAY),
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int EPN_W = WORD_W - PAGE_BITS,
  localparam int HALF  = NUM_WAYS * ENTRIES_PER_WAY,
  localparam int TOTAL = 2 * HALF,
  localparam int IDX_W = $clog2(TOTAL)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [EPN_W-1:0]  wrEpn,
  input  logic [WORD_W-1:0] wrWord0,
  input  logic [WORD_W-1:0] wrWord1,
  input  logic [SET_W-1:0]  lookupSet,
  input  logic              isFetch,
  input  xlatStrobe_t       strobe,
  input  logic [WAY_W-1:0]  bestWay,
  input  logic [2:0]        protIn,
  input  logic [WORD_W-1:0] pteIn,
  input  logic [WORD_W-1:0] realAddrIn,
  input  logic [WORD_W-1:0] reqMatch,
  output logic [EPN_W-1:0]  rdEpn [NUM_WAYS],
  output logic [WORD_W-1:0] rdW0  [NUM_WAYS],
  output logic [WORD_W-1:0] rdW1  [NUM_WAYS],
  output logic              rspValid,
  output logic [1:0]        rspCode,
  output logic [2:0]        rspProt,
  output logic [WORD_W-1:0] rspRealAddr,
  output logic [WORD_W-1:0] rspPte,
  output logic [WORD_W-1:0] missCmpInstr,
  output logic [WORD_W-1:0] missCmpData
);

  logic [EPN_W-1:0]  epnQ [TOTAL];
  logic [WORD_W-1:0] w0Q  [TOTAL];
  logic [WORD_W-1:0] w1Q  [TOTAL];
  logic [IDX_W-1:0]  rowIdx [NUM_WAYS];

  generate
    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
      assign rowIdx[g] = IDX_W'(g * ENTRIES_PER_WAY) + IDX_W'(lookupSet) +
                         (isFetch ? IDX_W'(HALF) : IDX_W'(0));
      assign rdEpn[g]  = epnQ[rowIdx[g]];
      assign rdW0[g]   = w0Q[rowIdx[g]];
      assign rdW1[g]   = w1Q[rowIdx[g]];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < TOTAL; i++) begin
        epnQ[i] <= '0;
        w0Q[i]  <= '0;
        w1Q[i]  <= '0;
      end
      rspValid     <= 1'b0;
      rspCode      <= RES_MISS;
      rspProt      <= '0;
      rspRealAddr  <= '0;
      rspPte       <= '0;
      missCmpInstr <= '0;
      missCmpData  <= '0;
    end else begin
      rspValid <= strobe.respond;
      if (strobe.respond) begin
        rspCode     <= strobe.code;
        rspProt     <= protIn;
        rspRealAddr <= realAddrIn;
        rspPte      <= pteIn;
      end
      if (strobe.latchImiss) begin
        missCmpInstr <= reqMatch;
      end
      if (strobe.latchDmiss) begin
        missCmpData <= reqMatch;
      end
      if (strobe.setRef) begin
        w1Q[rowIdx[bestWay]] <= pteIn;
      end
      // port write comes last so it overrides a same-entry write-back
      if (wrEn) begin
        epnQ[wrIdx] <= wrEpn;
        w0Q[wrIdx]  <= wrWord0;
        w1Q[wrIdx]  <= wrWord1;
      end
    end
  end

endmodule

// File: rtl/xlatBufLookup.sv
module xlatBufLookup
  import xlatBufPkg::*;
#(
  parameter int ENTRIES_PER_WAY = 32,
  parameter int NUM_WAYS        = 2,
  parameter int PAGE_BITS       = 12,
  localparam int EPN_W = WORD_W - PAGE_BITS,
  localparam int IDX_W = $clog2(2 * NUM_WAYS * ENTRIES_PER_WAY)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [WORD_W-1:0] reqAddr,
  input  logic [1:0]        reqAcc,
  input  logic [WORD_W-1:0] reqMatch,
  input  logic              reqKey,
  input  logic              reqNoExec,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [EPN_W-1:0]  wrEpn,
  input  logic [WORD_W-1:0] wrWord0,
  input  logic [WORD_W-1:0] wrWord1,
  output logic              rspValid,
  output logic [1:0]        rspCode,
  output logic [2:0]        rspProt,
  output logic [WORD_W-1:0] rspRealAddr,
  output logic [WORD_W-1:0] rspPte,
  output logic [WORD_W-1:0] missCmpInstr,
  output logic [WORD_W-1:0] missCmpData
);

  localparam int SET_W = $clog2(ENTRIES_PER_WAY);
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1;

  logic [EPN_W-1:0]  rdEpn [NUM_WAYS];
  logic [WORD_W-1:0] rdW0  [NUM_WAYS];
  logic [WORD_W-1:0] rdW1  [NUM_WAYS];
  logic [SET_W-1:0]  lookupSet;
  logic              isFetch;
  xlatStrobe_t       strobe;
  logic [WAY_W-1:0]  bestWay;
  logic [2:0]        protC;
  logic [WORD_W-1:0] pteC;
  logic [WORD_W-1:0] realAddrC;

  xlatBufCtrl #(
    .ENTRIES_PER_WAY(ENTRIES_PER_WAY), .NUM_WAYS(NUM_WAYS), .PAGE_BITS(PAGE_BITS)
  ) u_ctrl (
    .reqValid(reqValid), .reqAddr(reqAddr), .reqAcc(reqAcc), .reqMatch(reqMatch),
    .reqKey(reqKey), .reqNoExec(reqNoExec),
    .rdEpn(rdEpn), .rdW0(rdW0), .rdW1(rdW1),
    .lookupSet(lookupSet), .isFetch(isFetch), .strobe(strobe), .bestWay(bestWay),
    .protOut(protC), .pteOut(pteC), .realAddrOut(realAddrC)
  );

  xlatBufData #(
    .ENTRIES_PER_WAY(ENTRIES_PER_WAY), .NUM_WAYS(NUM_WAYS), .PAGE_BITS(PAGE_BITS)
  ) u_data (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrEpn(wrEpn), .wrWord0(wrWord0), .wrWord1(wrWord1),
    .lookupSet(lookupSet), .isFetch(isFetch), .strobe(strobe), .bestWay(bestWay),
    .protIn(protC), .pteIn(pteC), .realAddrIn(realAddrC), .reqMatch(reqMatch),
    .rdEpn(rdEpn), .rdW0(rdW0), .rdW1(rdW1),
    .rspValid(rspValid), .rspCode(rspCode), .rspProt(rspProt),
    .rspRealAddr(rspRealAddr), .rspPte(rspPte),
    .missCmpInstr(missCmpInstr), .missCmpData(missCmpData)
  );

endmodule

// File: rtl/xlatBufChecker.sv
module xlatBufChecker
  import xlatBufPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [1:0]        reqAcc,
  input logic [WORD_W-1:0] reqMatch,
  input logic              rspValid,
  input logic [1:0]        rspCode,
  input logic [2:0]        rspProt,
  input logic [WORD_W-1:0] rspPte,
  input logic [WORD_W-1:0] missCmpInstr,
  input logic [WORD_W-1:0] missCmpData
);

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R9

  AST_NO_IDLE_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid); // R9

  AST_IMISS_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAcc != ACC_FETCH) |=> $stable(missCmpInstr)); // R8

  AST_DMISS_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAcc == ACC_FETCH) |=> $stable(missCmpData)); // R8

  AST_IMISS_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAcc == ACC_FETCH) |=>
      (rspCode != RES_MISS || missCmpInstr == $past(reqMatch))); // R8

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> rspCode != 2'b11); // R5

  AST_MISS_NO_PROT: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCode == RES_MISS) |-> rspProt == 3'b000); // R5

  AST_REF_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCode != RES_MISS) |-> rspPte[REF_BIT]); // R6

  AST_WRITE_NEEDS_CHG: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspProt[1]) |-> rspPte[CHG_BIT]); // R7

endmodule

bind xlatBufLookup xlatBufChecker u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAcc(reqAcc), .reqMatch(reqMatch),
  .rspValid(rspValid), .rspCode(rspCode), .rspProt(rspProt), .rspPte(rspPte),
  .missCmpInstr(missCmpInstr), .missCmpData(missCmpData)
);

// File: tb/xlatBufLookup_bench.sv
module xlatBufLookup_bench;

  localparam int EPW   = 32;
  localparam int NW    = 2;
  localparam int HALFN = EPW * NW;
  localparam int TOT   = 2 * HALFN;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqAcc = '0;
  logic [31:0] reqMatch = '0;
  logic        reqKey = 1'b0;
  logic        reqNoExec = 1'b0;
  logic        wrEn = 1'b0;
  logic [6:0]  wrIdx = '0;
  logic [19:0] wrEpn = '0;
  logic [31:0] wrWord0 = '0;
  logic [31:0] wrWord1 = '0;
  logic        rspValid;
  logic [1:0]  rspCode;
  logic [2:0]  rspProt;
  logic [31:0] rspRealAddr;
  logic [31:0] rspPte;
  logic [31:0] missCmpInstr;
  logic [31:0] missCmpData;

  always #10 clk = ~clk;

  xlatBufLookup u_xlatBufLookup (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqAcc(reqAcc),
    .reqMatch(reqMatch), .reqKey(reqKey), .reqNoExec(reqNoExec),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrEpn(wrEpn), .wrWord0(wrWord0), .wrWord1(wrWord1),
    .rspValid(rspValid), .rspCode(rspCode), .rspProt(rspProt),
    .rspRealAddr(rspRealAddr), .rspPte(rspPte),
    .missCmpInstr(missCmpInstr), .missCmpData(missCmpData)
  );

  // behavioural reference state
  logic [19:0] mEpn [TOT];
  logic [31:0] mW0  [TOT];
  logic [31:0] mW1  [TOT];
  logic [31:0] mIm;
  logic [31:0] mDm;

  int  nChecks = 0;
  int  nFail   = 0;
  bit  finished = 1'b0;

  localparam logic [31:0] V  = 32'h8000_0000;
  localparam logic [31:0] M1 = 32'h0012_3415;
  localparam logic [31:0] M2 = 32'h0005_5501;

  task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s got %h expected %h", what, got, exp);
    end
  endtask

  function automatic logic [2:0] refPerm(input bit key, input logic [1:0] pp, input bit nx);
    bit canRead;
    bit canWrite;
    canRead  = key ? (pp != 2'd0) : 1'b1;
    canWrite = key ? (pp == 2'd2) : (pp != 2'd3);
    return {canRead && !nx, canWrite, canRead};
  endfunction

  task automatic doCycle(input bit lk, input logic [31:0] a, input logic [1:0] acc,
                         input logic [31:0] m, input bit key, input bit nx,
                         input bit we, input int widx, input logic [19:0] wepn,
                         input logic [31:0] w0, input logic [31:0] w1, input string tag);
    int set;
    int base;
    int best;
    bit found;
    bit ok;
    logic [31:0] refW;
    logic [2:0] prot;
    logic [1:0] eCode;
    logic [31:0] ePte;
    logic [31:0] eReal;
    logic [2:0] eProt;
    set = (a >> 12) % EPW;
    base = (acc == 2'b10) ? HALFN : 0;
    found = 0; ok = 0; best = -1; refW = '0; prot = '0;
    for (int w = 0; w < NW; w++) begin
      int i;
      i = base + w * EPW + set;
      if (!ok && mW0[i][31] && !mW0[i][6] && ((mW0[i] ^ m) & 32'h7FFF_FFBF) == 0 &&
          mEpn[i] == a[31:12]) begin
        if (!found || ((mW1[i] ^ refW) & 32'hFFFF_F07B) == 0) begin
          found = 1; best = i; refW = mW1[i];
          prot = refPerm(key, refW[1:0], nx);
          ok = (acc == 2'b10) ? prot[2] : (acc == 2'b01) ? prot[1] : prot[0];
        end
      end
    end
    eCode = ok ? 2'b00 : found ? 2'b01 : 2'b10;
    ePte = '0; eReal = '0; eProt = '0;
    if (found) begin
      ePte = refW | 32'h100;
      if (!refW[7]) begin
        if (acc == 2'b01 && ok) ePte = ePte | 32'h80;
        else prot[1] = 1'b0;
      end
      eProt = prot;
      eReal = {refW[31:12], a[11:0]};
    end
    if (lk) begin
      if (found) mW1[best] = ePte;
      else if (acc == 2'b10) mIm = m;
      else mDm = m;
    end
    if (we) begin
      mEpn[widx] = wepn; mW0[widx] = w0; mW1[widx] = w1;
    end
    reqValid = lk; reqAddr = a; reqAcc = acc; reqMatch = m; reqKey = key; reqNoExec = nx;
    wrEn = we; wrIdx = 7'(widx); wrEpn = wepn; wrWord0 = w0; wrWord1 = w1;
    @(negedge clk);
    reqValid = 1'b0; wrEn = 1'b0;
    if (lk) begin
      check({tag, " R9 valid"}, 32'(rspValid), 32'd1);
      check({tag, " R5 code"}, 32'(rspCode), 32'(eCode));
      check({tag, " R4 R7 prot"}, 32'(rspProt), 32'(eProt));
      check({tag, " R9 real"}, rspRealAddr, eReal);
      check({tag, " R6 R7 pte"}, rspPte, ePte);
    end else begin
      check({tag, " R9 idle valid"}, 32'(rspValid), 32'd0);
    end
    check({tag, " R8 imiss"}, missCmpInstr, mIm);
    check({tag, " R8 dmiss"}, missCmpData, mDm);
  endtask

  task automatic look(input logic [31:0] a, input logic [1:0] acc, input logic [31:0] m,
                      input bit key, input bit nx, input string tag);
    doCycle(1'b1, a, acc, m, key, nx, 1'b0, 0, '0, '0, '0, tag);
  endtask

  task automatic wr(input int idx, input logic [19:0] epn, input logic [31:0] w0,
                    input logic [31:0] w1);
    doCycle(1'b0, '0, 2'b00, '0, 1'b0, 1'b0, 1'b1, idx, epn, w0, w1, "R11 write");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL R9 watchdog expired got 0 expected 1");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < TOT; i++) begin
      mEpn[i] = '0; mW0[i] = '0; mW1[i] = '0;
    end
    mIm = '0; mDm = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 reset valid", 32'(rspValid), 32'd0);
    check("R10 reset imiss", missCmpInstr, 32'd0);
    check("R10 reset dmiss", missCmpData, 32'd0);

    look(32'h0000_3456, 2'b00, M1, 0, 0, "R10 empty load miss");
    look(32'h0000_3456, 2'b10, M2, 0, 0, "R8 fetch miss");

    wr(3, 20'h00003, V | M1, 32'hABCD_E02A);
    look(32'h0000_3456, 2'b00, M1, 0, 0, "R7 load before change");
    look(32'h0000_3456, 2'b01, M1, 0, 0, "R7 first store");
    look(32'h0000_3456, 2'b00, M1, 0, 0, "R7 load after change");
    look(32'h0000_3456, 2'b10, M1, 0, 0, "R1 fetch uses instr half");

    wr(HALFN + 3, 20'h00003, V | M1, 32'h1234_5001);
    look(32'h0000_3010, 2'b10, M1, 1, 0, "R4 fetch key1 pp1");
    look(32'h0000_3010, 2'b10, M1, 1, 1, "R4 fetch no-exec");

    wr(5, 20'h00005, V | M1, 32'h0000_1000);
    look(32'h0000_5000, 2'b00, M1, 1, 0, "R6 key1 pp0 fault");
    look(32'h0000_5000, 2'b00, M1, 0, 0, "R4 key0 pp0 load");

    wr(6, 20'h00006, V | M1 | 32'h40, 32'h0000_2002);
    look(32'h0000_6000, 2'b00, M1, 0, 0, "R2 hash select set");
    wr(7, 20'h00007, M1, 32'h0000_2002);
    look(32'h0000_7000, 2'b00, M1, 0, 0, "R2 invalid entry");
    wr(8, 20'h00008, V | M1, 32'h0000_3002);
    look(32'h0000_8000, 2'b00, M2, 0, 0, "R2 match word differs");
    look(32'h0010_8000, 2'b00, M1, 0, 0, "R2 page number differs");
    look(32'h0000_8000, 2'b00, M1, 0, 0, "R2 full match");

    wr(EPW + 9, 20'h00009, V | M1, 32'h0777_7002);
    look(32'h0000_9ABC, 2'b00, M1, 0, 0, "R2 way1 hit");

    wr(10, 20'h0000A, V | M1, 32'h1111_1003);
    wr(EPW + 10, 20'h0000A, V | M1, 32'h2222_2002);
    look(32'h0000_A000, 2'b01, M1, 0, 0, "R3 inconsistent way ignored");

    wr(11, 20'h0000B, V | M1, 32'h3333_3003);
    wr(EPW + 11, 20'h0000B, V | M1, 32'h3333_3003);
    look(32'h0000_B000, 2'b01, M1, 0, 0, "R5 consistent ways fault");
    look(32'h0000_B000, 2'b00, M1, 0, 0, "R5 consistent ways hit");

    wr(EPW - 1, 20'h0001F, V | M1, 32'h4444_4002);
    look(32'h0001_FFFF, 2'b00, M1, 0, 0, "R1 last set");
    wr(0, 20'h00020, V | M1, 32'h4545_4002);
    look(32'h0002_0004, 2'b00, M1, 0, 0, "R1 set wrap");
    wr(HALFN + EPW, 20'h00020, V | M2, 32'h4646_4002);
    look(32'h0002_0010, 2'b10, M2, 0, 0, "R1 instr way1 set0");

    doCycle(1'b1, 32'h0000_3000, 2'b00, M1, 0, 0, 1'b1, 3, 20'h00003, V | M1,
            32'h5555_5002, "R11 write with lookup");
    look(32'h0000_3000, 2'b00, M1, 0, 0, "R11 write wins");
    look(32'h0000_3000, 2'b11, M1, 0, 0, "R4 kind 11 as load");

    repeat (2) doCycle(1'b0, '0, 2'b00, '0, 0, 0, 1'b0, 0, '0, '0, '0, "R9 idle");

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule